// File: doc/BRIEF.md
# Angle-to-Density Delta-Sigma Output Encoder

This block converts an interpolated position count into a one-bit pulse-density stream whose long-run fraction of ones equals the electrical angle within the current input cycle, expressed as a fraction of full scale. A first-order delta-sigma accumulator produces the bits. The output therefore spreads its ones across each frame instead of forming one contiguous high pulse per period. The stream is driven as a complementary pair. A sample clock is provided whose rising edge falls in the middle of every bit, so a digital receiver can capture and decimate the stream synchronously. A frame strobe marks the first bit of every modulator frame of 2^ANG_W bits.

The resolution input selects how many position steps make up one input cycle, as a power of two. In wrap mode the angle repeats every cycle. In clamp mode, meant for single-turn absolute use, the angle saturates at empty or full outside the first cycle. The angle is captured only at frame boundaries, so every frame carries exactly one angle value. The index input is passed straight through to its output.

Top module: `ang_dsm_enc`

## Requirements
- R1: While `rst` is high and until the first bit completes afterwards, `dout_p_o`=0, `dout_n_o`=1, `frame_o`=0 and `sclk_o`=0. The accumulator and the frame position are cleared, so the first frame starts with the frame strobe.
- R2: `dout_n_o` is always the complement of `dout_p_o`.
- R3: For a frame of 2^ANG_W bits, starting at the bit where `frame_o` is high, the number of ones on `dout_p_o` equals the angle code A captured for that frame (0 ≤ A ≤ 2^ANG_W).
- R4: With `clamp_i`=0, the cycle length is 2^k steps with k = `res_sel_i`, and A = (pos mod 2^k)·2^ANG_W / 2^k. The angle wraps on every cycle, including for negative two's-complement positions.
- R5: A `res_sel_i` code above 10 acts exactly as 10, so the cycle length never exceeds 1024 steps.
- R6: With `clamp_i`=1, a position whose MSB is set (negative) gives A=0, a position of 2^k or more gives A=2^ANG_W (all ones), and any other position maps as in R4.
- R7: The angle is captured only at the first bit of a frame. Input changes during a frame do not alter that frame's count and take effect in the next frame.
- R8: `frame_o` is high for exactly one bit time, and it rises once every 2^ANG_W bits.
- R9: Each bit lasts BIT_DIV clocks. `sclk_o` is low for the first half of a bit and rises BIT_DIV/2 clocks after the bit changes.
- R10: With A = 2^(ANG_W-1), successive output bits alternate. This is the density behaviour, not one long pulse.
- R11: `index_o` equals `index_i` combinationally, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_i | input | POS_W | Interpolated position count, two's complement |
| res_sel_i | input | 4 | log2 of steps per input cycle (codes above 10 act as 10) |
| clamp_i | input | 1 | 1 = saturating single-turn angle, 0 = wrapping angle |
| index_i | input | 1 | Index pulse input |
| dout_p_o | output | 1 | Density stream, true polarity |
| dout_n_o | output | 1 | Density stream, inverted polarity |
| sclk_o | output | 1 | Sample clock, rising mid-bit |
| frame_o | output | 1 | High during the first bit of each frame |
| index_o | output | 1 | Index pulse passthrough |

## Verification
A corrupted accumulator or a wrong angle mapping shows up as a ones count that differs from the expected code within the first complete frame after the inputs settle, which takes at most two frames of 2^ANG_W bits. A broken frame counter or angle latch shows up in the same frame as a misplaced strobe or as mixed densities when the position changes mid-frame. Faults in the bit divider appear within one bit time as a wrong sample-clock phase relative to the frame strobe.

// File: rtl/ang_dsm_pkg.sv
package ang_dsm_pkg;

    // Width of the resolution select code and its largest legal value
    localparam int RES_SEL_W   = 4;
    localparam int RES_LOG_MAX = 10;

    typedef logic [RES_SEL_W-1:0] res_sel_t;

    typedef enum logic {
        MODE_WRAP = 1'b0,
        MODE_SAT  = 1'b1
    } turn_mode_e;

    // One modulator output slot: the stream bit and its frame marker
    typedef struct packed {
        logic bit_v;
        logic frame_v;
    } dsm_out_t;

    // Saturate the resolution select to the maximum cycle length
    function automatic res_sel_t limit_res(input res_sel_t sel);
        return (sel > res_sel_t'(RES_LOG_MAX)) ? res_sel_t'(RES_LOG_MAX) : sel;
    endfunction

endpackage

// File: rtl/ang_tick_gen.sv
module ang_tick_gen #(
    parameter int BIT_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o,
    output logic sclk_o
);
    localparam int DC_W = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [DC_W-1:0] DC_LAST = DC_W'(BIT_DIV - 1);
    localparam logic [DC_W-1:0] DC_MID  = DC_W'(BIT_DIV / 2 - 1);

    logic [DC_W-1:0] dc_q;

    // Last clock of a bit: the modulator advances on this edge
    assign tick_o = (dc_q == DC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            dc_q   <= '0;
            sclk_o <= 1'b0;
        end else begin
            dc_q <= tick_o ? '0 : dc_q + 1'b1;
            if (dc_q == DC_MID) begin
                sclk_o <= 1'b1;
            end else if (tick_o) begin
                sclk_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ang_map.sv
module ang_map
    import ang_dsm_pkg::*;
#(
    parameter int POS_W = 16,
    parameter int ANG_W = 8
) (
    input  logic [POS_W-1:0] pos_i,
    input  res_sel_t         res_sel_i,
    input  turn_mode_e       mode_i,
    output logic [ANG_W:0]   ang_o
);
    localparam logic [ANG_W:0] ANG_FULL = {1'b1, {ANG_W{1'b0}}};

    res_sel_t         k;
    logic [POS_W-1:0] phase;
    logic [POS_W-1:0] whole;

    always_comb begin
        k     = limit_res(res_sel_i);
        phase = pos_i & ~({POS_W{1'b1}} << k);
        whole = pos_i >> k;
        // phase < 2^k, so the rescaled value always fits in ANG_W bits
        ang_o = {1'b0, ANG_W'({phase, {ANG_W{1'b0}}} >> k)};
        if (mode_i == MODE_SAT) begin
            if (pos_i[POS_W-1]) begin
                ang_o = '0;
            end else if (whole != '0) begin
                ang_o = ANG_FULL;
            end
        end
    end
endmodule

// File: rtl/ang_dsm_core.sv
module ang_dsm_core
    import ang_dsm_pkg::*;
#(
    parameter int ANG_W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_i,
    input  logic [ANG_W:0] ang_i,
    output dsm_out_t       out_o
);
    logic [ANG_W-1:0] acc_q;
    logic [ANG_W-1:0] slot_q;
    logic [ANG_W:0]   ang_q;
    logic [ANG_W:0]   ang_use;
    logic [ANG_W:0]   sum;
    logic             frame_start;

    always_comb begin
        frame_start = (slot_q == '0);
        ang_use     = frame_start ? ang_i : ang_q;
        sum         = {1'b0, acc_q} + ang_use;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            slot_q <= '0;
            ang_q  <= '0;
            out_o  <= '0;
        end else if (tick_i) begin
            acc_q         <= sum[ANG_W-1:0];
            slot_q        <= slot_q + 1'b1;
            out_o.bit_v   <= sum[ANG_W];
            out_o.frame_v <= frame_start;
            if (frame_start) begin
                ang_q <= ang_i;
            end
        end
    end
endmodule

// File: rtl/ang_dsm_enc.sv
module ang_dsm_enc
    import ang_dsm_pkg::*;
#(
    parameter int POS_W   = 16,
    parameter int ANG_W   = 8,
    parameter int BIT_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [POS_W-1:0]     pos_i,
    input  logic [RES_SEL_W-1:0] res_sel_i,
    input  logic                 clamp_i,
    input  logic                 index_i,
    output logic                 dout_p_o,
    output logic                 dout_n_o,
    output logic                 sclk_o,
    output logic                 frame_o,
    output logic                 index_o
);
    turn_mode_e     mode;
    logic [ANG_W:0] ang;
    logic           tick;
    dsm_out_t       dsm_out;

    assign mode = clamp_i ? MODE_SAT : MODE_WRAP;

    ang_tick_gen #(.BIT_DIV(BIT_DIV)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick),
        .sclk_o (sclk_o)
    );

    ang_map #(.POS_W(POS_W), .ANG_W(ANG_W)) u_map (
        .pos_i     (pos_i),
        .res_sel_i (res_sel_i),
        .mode_i    (mode),
        .ang_o     (ang)
    );

    ang_dsm_core #(.ANG_W(ANG_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick),
        .ang_i  (ang),
        .out_o  (dsm_out)
    );

    assign dout_p_o = dsm_out.bit_v;
    assign dout_n_o = ~dsm_out.bit_v;
    assign frame_o  = dsm_out.frame_v;
    assign index_o  = index_i;
endmodule

// File: rtl/ang_dsm_enc_chk.sv
module ang_dsm_enc_chk #(
    parameter int ANG_W   = 8,
    parameter int BIT_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic dout_p_o,
    input logic sclk_o,
    input logic frame_o
);
    localparam int FRAME_BITS = 1 << ANG_W;

    logic rst_d;
    logic sclk_d;
    logic frame_d;
    logic dout_d;
    logic sclk_armed;
    logic frame_armed;
    int   clk_cnt;
    int   bit_cnt;
    int   hold_cnt;
    logic sclk_rise;
    logic frame_rise;
    logic frame_fall;

    assign sclk_rise  = sclk_o && !sclk_d;
    assign frame_rise = frame_o && !frame_d;
    assign frame_fall = !frame_o && frame_d;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            sclk_d      <= 1'b0;
            frame_d     <= 1'b0;
            dout_d      <= 1'b0;
            sclk_armed  <= 1'b0;
            frame_armed <= 1'b0;
            clk_cnt     <= 0;
            bit_cnt     <= 0;
            hold_cnt    <= 0;
        end else begin
            sclk_d  <= sclk_o;
            frame_d <= frame_o;
            dout_d  <= dout_p_o;
            clk_cnt <= sclk_rise ? 1 : clk_cnt + 1;
            if (sclk_rise) sclk_armed <= 1'b1;
            if (frame_rise) begin
                frame_armed <= 1'b1;
                bit_cnt     <= 0;
                hold_cnt    <= 1;
            end else begin
                hold_cnt <= hold_cnt + 1;
                if (sclk_rise) bit_cnt <= bit_cnt + 1;
            end
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_d) begin
            reset_state_chk: assert (!dout_p_o && !sclk_o && !frame_o);
        end
    end

    // R9
    sclk_period_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_rise && sclk_armed) |-> (clk_cnt == BIT_DIV));

    // R9
    bit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_p_o != dout_d) |-> !sclk_o);

    // R8
    frame_period_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_rise && frame_armed) |-> (bit_cnt == FRAME_BITS));

    // R8
    frame_width_chk: assert property (@(posedge clk) disable iff (rst)
        frame_fall |-> (hold_cnt == BIT_DIV));
endmodule

bind ang_dsm_enc ang_dsm_enc_chk #(
    .ANG_W   (ANG_W),
    .BIT_DIV (BIT_DIV)
) u_ang_dsm_enc_chk (
    .clk      (clk),
    .rst      (rst),
    .dout_p_o (dout_p_o),
    .sclk_o   (sclk_o),
    .frame_o  (frame_o)
);

// File: tb/ang_dsm_enc_bench.sv
module ang_dsm_enc_bench;
    localparam int POS_W      = 16;
    localparam int ANG_W      = 8;
    localparam int BIT_DIV    = 4;
    localparam int FRAME_BITS = 1 << ANG_W;

    logic             clk     = 1'b0;
    logic             rst     = 1'b1;
    logic [POS_W-1:0] pos     = '0;
    logic [3:0]       res_sel = 4'd8;
    logic             clamp   = 1'b0;
    logic             index   = 1'b0;
    logic             dout_p;
    logic             dout_n;
    logic             sclk;
    logic             frame;
    logic             index_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 50 MHz
    always #10 clk = ~clk;

    ang_dsm_enc #(
        .POS_W   (POS_W),
        .ANG_W   (ANG_W),
        .BIT_DIV (BIT_DIV)
    ) u_ang_dsm_enc (
        .clk       (clk),
        .rst       (rst),
        .pos_i     (pos),
        .res_sel_i (res_sel),
        .clamp_i   (clamp),
        .index_i   (index),
        .dout_p_o  (dout_p),
        .dout_n_o  (dout_n),
        .sclk_o    (sclk),
        .frame_o   (frame),
        .index_o   (index_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One mid-bit sample; returns at a falling clock edge
    task automatic sample_bit(output logic b, output logic f, output logic bn);
        @(posedge sclk);
        @(negedge clk);
        b  = dout_p;
        f  = frame;
        bn = dout_n;
    endtask

    // Capture one full frame from its strobe; optionally change pos mid-frame
    task automatic read_frame(input int change_at, input logic [POS_W-1:0] new_pos,
                              output int ones, output int comp_bad,
                              output int alt_bad, output int strobe_bad,
                              output int next_strobe);
        logic b, f, bn, prev;
        ones = 0; comp_bad = 0; alt_bad = 0; strobe_bad = 0;
        prev = 1'b0;
        f = 1'b0;
        while (!f) sample_bit(b, f, bn);
        for (int i = 0; i < FRAME_BITS; i++) begin
            if (i > 0) begin
                sample_bit(b, f, bn);
                if (f) strobe_bad++;
                if (b == prev) alt_bad++;
            end
            if (b) ones++;
            if (bn == b) comp_bad++;
            prev = b;
            if (i == change_at) pos = new_pos;
        end
        sample_bit(b, f, bn);
        next_strobe = int'(f);
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        // R1: reset values while held in reset
        check("R1", "dout_p in reset", int'(dout_p), 0);
        check("R1", "dout_n in reset", int'(dout_n), 1);
        check("R1", "frame in reset", int'(frame), 0);
        check("R1", "sclk in reset", int'(sclk), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "dout_p after release", int'(dout_p), 0);
    endtask

    task automatic t_density(input string req, input logic [POS_W-1:0] p,
                             input logic [3:0] sel, input logic cl, input int exp);
        logic b, f, bn;
        int ones, comp_bad, alt_bad, strobe_bad, nxt;
        sample_bit(b, f, bn);
        pos = p; res_sel = sel; clamp = cl;
        read_frame(-1, p, ones, comp_bad, alt_bad, strobe_bad, nxt);
        check(req, "R3 ones per frame", ones, exp);
        check("R2", "complement mismatches", comp_bad, 0);
        check("R8", "extra strobes in frame", strobe_bad, 0);
        check("R8", "strobe after 2^N bits", nxt, 1);
    endtask

    task automatic t_alternate();
        logic b, f, bn;
        int ones, comp_bad, alt_bad, strobe_bad, nxt;
        sample_bit(b, f, bn);
        pos = 16'h0080; res_sel = 4'd8; clamp = 1'b0;
        read_frame(-1, pos, ones, comp_bad, alt_bad, strobe_bad, nxt);
        check("R10", "repeated bits at half scale", alt_bad, 0);
        check("R10", "ones at half scale", ones, 128);
    endtask

    task automatic t_midframe();
        logic b, f, bn;
        int ones, comp_bad, alt_bad, strobe_bad, nxt;
        sample_bit(b, f, bn);
        pos = 16'd64; res_sel = 4'd8; clamp = 1'b0;
        // frame with angle 64; pos changes to 200 after bit 100
        read_frame(100, 16'd200, ones, comp_bad, alt_bad, strobe_bad, nxt);
        check("R7", "frame with mid-frame change", ones, 64);
        read_frame(-1, pos, ones, comp_bad, alt_bad, strobe_bad, nxt);
        check("R7", "next frame uses new angle", ones, 200);
    endtask

    task automatic t_timing();
        int n;
        @(posedge frame);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sclk && n < 4 * BIT_DIV);
        // R9: rise BIT_DIV/2 clocks after the bit edge, seen at the following negedge
        check("R9", "sclk rise delay", n, BIT_DIV / 2 + 1);
        n = 0;
        @(posedge sclk);
        do begin
            @(negedge clk);
            n++;
        end while (!(sclk == 1'b0) && n < 4 * BIT_DIV);
        check("R9", "sclk high clocks", n, BIT_DIV / 2 + 1);
    endtask

    task automatic t_index();
        clamp = 1'b0; index = 1'b1; #1;
        check("R11", "index high, wrap", int'(index_o), 1);
        clamp = 1'b1; #1;
        check("R11", "index high, clamp", int'(index_o), 1);
        index = 1'b0; #1;
        check("R11", "index low, clamp", int'(index_o), 0);
        clamp = 1'b0; #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_index();
        t_timing();
        t_density("R4", 16'h0140, 4'd8,  1'b0, 64);
        t_density("R4", 16'h0013, 4'd4,  1'b0, 48);
        t_density("R4", 16'h0A00, 4'd10, 1'b0, 128);
        t_density("R4", 16'hFFFF, 4'd8,  1'b0, 255);
        t_density("R4", 16'd300,  4'd8,  1'b0, 44);
        t_density("R4", 16'h0000, 4'd8,  1'b0, 0);
        t_density("R5", 16'h0A00, 4'd15, 1'b0, 128);
        t_density("R5", 16'h0A00, 4'd11, 1'b0, 128);
        t_density("R6", 16'hFFF0, 4'd8,  1'b1, 0);
        t_density("R6", 16'd300,  4'd8,  1'b1, 256);
        t_density("R6", 16'd100,  4'd8,  1'b1, 100);
        t_alternate();
        t_midframe();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule